// File: doc/BRIEF.md
# Serial Bus Acknowledge and Busy Handshake Controller

This block handles the handshake part of a clocked 8-bit serial bus port. It watches the serial clock and the data line, and it receives single-cycle command and release pulses from a separate bus-condition detector. From these it decides when to pull the data line low. It pulls the line low for one bit to acknowledge a byte. It can then hold the line low as a busy signal until software lets it go. It also keeps two status flags: one records that a command condition was seen, and one records that the far end acknowledged.

Software uses a single control/status register and a transfer-start strobe. The control bits are:
- a one-shot acknowledge trigger, which sends an acknowledge at the next serial clock falling edge;
- an automatic-acknowledge enable, which sends the acknowledge at the falling edge that follows the last data bit;
- a busy enable, which holds the line low after an acknowledge.

An interface enable input resets the handshake state while the port is off. The serial clock is sampled by the system clock through a synchroniser, and falling and rising edges are found from the synchronised level. The block counts falling edges from each transfer start by itself. The shift register, address matching and clock generation lie outside this block.

Top module: `serbus_ack_busy`

## Requirements
- R1: After reset, every register bit reads 0 and the data line is not pulled low.
- R2: Writing 1 to register bit 0 (one-shot acknowledge trigger) makes the block pull the line low at the next detected serial clock falling edge. The trigger clears itself at that edge, and bit 0 always reads 0.
- R3: With register bit 1 (automatic acknowledge) at 1, the line is pulled low at the falling edge that follows the 8th falling edge after a transfer start, and at no earlier edge. This holds whether the bit was written before or after those 8 edges.
- R4: With bits 0 and 1 both 0, no acknowledge is driven.
- R5: An acknowledge lasts exactly one serial bit. The next falling edge ends it, unless a busy level or a new acknowledge takes over.
- R6: With register bit 2 (busy enable) at 1, the line is held low from the falling edge that ends an acknowledge. The hold lasts until a falling edge is seen while bit 2 is 0.
- R7: A transfer start releases the line at once, clears busy and any pending acknowledge, and leaves bit 2 unchanged.
- R8: Register bit 3 (acknowledge detected) is set when the data input is low at the first rising edge after the 9th falling edge since a transfer start. A high level at that edge leaves it clear.
- R9: After a transfer start, bit 3 is cleared at the next falling edge.
- R10: Register bit 4 (command detected) is set by a command pulse. It is cleared by a transfer start or a release pulse, and a clear in the same cycle as a command pulse wins.
- R11: While the interface enable is 0, bits 0, 3 and 4 are held at 0 and the line is released. Bits 1 and 2 keep their values and can still be written.
- R12: Register writes load bits 1 and 2 directly. Written values for bits 3 to 7 are ignored, and bits 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_en | input | 1 | Interface enable |
| scl_in | input | 1 | Serial clock level (asynchronous) |
| sda_in | input | 1 | Data line level |
| cmd_pulse | input | 1 | Command condition seen, one cycle |
| rel_pulse | input | 1 | Bus release seen, one cycle |
| xfer_start | input | 1 | Transfer start strobe, one cycle |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sda_pull_low | output | 1 | Drive the data line low (open drain) |

## Verification
The hardest state to reach is a busy level that started from an acknowledge, followed by a transfer start that must drop it while the busy-enable bit stays set. Getting there takes a full byte of serial clocks, an automatic acknowledge and one more falling edge. The bench drives the serial clock as slow bit phases and runs a complete nine-bit transfer with busy enabled. It then holds the line through one more bit and strobes a transfer start in the middle of a high phase. A behavioural model runs alongside the design and shows at which cycle each edge takes effect.

// File: rtl/serbus_ab_pkg.sv
// Package: shared register field positions for the handshake controller.
// Assumes an 8-bit control/status register.
package serbus_ab_pkg;
    localparam int REG_W      = 8;
    localparam int F_TRIG     = 0;   // one-shot acknowledge trigger, reads 0
    localparam int F_AUTO     = 1;   // automatic acknowledge enable
    localparam int F_BUSY     = 2;   // busy enable
    localparam int F_ACKSEEN  = 3;   // acknowledge detected (read only)
    localparam int F_CMDSEEN  = 4;   // command detected (read only)

    typedef struct packed {
        logic auto_ack;
        logic busy_en;
    } ctrl_t;
endpackage

// File: rtl/sbh_edge_sync.sv
// Synchronises the serial clock level into the system clock domain and
// gives one-cycle pulses for its falling and rising edges.
// Assumes the serial clock is much slower than clk.
module sbh_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fall,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    // Shift the level through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[DEPTH-2:0], line_in};
    end

    assign fall = chain[DEPTH-1] & ~chain[DEPTH-2];
    assign rise = ~chain[DEPTH-1] & chain[DEPTH-2];
endmodule

// File: rtl/sbh_bit_counter.sv
// Counts serial clock falling edges since the last transfer start.
// The count saturates one past the data bits, so the acknowledge bit
// position can be told apart from the data bits.
module sbh_bit_counter #(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic fall,
    output logic data_done,
    output logic ack_slot
);
    localparam int CW  = $clog2(BITS + 2);
    localparam logic [CW-1:0] LAST = CW'(BITS + 1);

    logic [CW-1:0] cnt;

    // Restart on a transfer start and step on each falling edge until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)            cnt <= '0;
        else if (start)               cnt <= '0;
        else if (fall && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign data_done = (cnt == CW'(BITS));
    assign ack_slot  = (cnt == LAST);
endmodule

// File: rtl/sbh_line_ctrl.sv
// Decides when the data line is pulled low: a one-bit acknowledge from
// the one-shot trigger or the automatic enable, then an optional busy level.
// Assumes fall is a single-cycle pulse.
module sbh_line_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic fall,
    input  logic data_done,
    input  logic trig_set,
    input  logic auto_ack,
    input  logic busy_en,
    output logic ack_drive,
    output logic busy
);
    logic trig;

    // One-shot trigger: set by write, cleared at the edge that uses it.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  trig <= 1'b0;
        else if (start)     trig <= 1'b0;
        else if (trig_set)  trig <= 1'b1;
        else if (fall)      trig <= 1'b0;
    end

    // Acknowledge lasts from one falling edge to the next.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  ack_drive <= 1'b0;
        else if (start)     ack_drive <= 1'b0;
        else if (fall)      ack_drive <= trig | (auto_ack & data_done);
    end

    // Busy starts after an acknowledge and stops at a falling edge without busy enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  busy <= 1'b0;
        else if (start)     busy <= 1'b0;
        else if (fall) begin
            if (ack_drive && busy_en) busy <= 1'b1;
            else if (!busy_en)        busy <= 1'b0;
        end
    end
endmodule

// File: rtl/sbh_status.sv
// Holds the command-detected and acknowledge-detected flags with their
// own clear conditions. Assumes pulses are one cycle wide.
module sbh_status (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic fall,
    input  logic rise,
    input  logic ack_slot,
    input  logic sda_in,
    input  logic cmd_pulse,
    input  logic rel_pulse,
    output logic cmd_seen,
    output logic ack_seen
);
    logic clr_pend;

    // Command flag: clears win over a command pulse in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)          cmd_seen <= 1'b0;
        else if (start || rel_pulse) cmd_seen <= 1'b0;
        else if (cmd_pulse)         cmd_seen <= 1'b1;
    end

    // Remember that a start asked for the acknowledge flag to clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) clr_pend <= 1'b0;
        else if (start)    clr_pend <= 1'b1;
        else if (fall)     clr_pend <= 1'b0;
    end

    // Acknowledge flag: cleared at the first falling edge after start, set by a low sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                   ack_seen <= 1'b0;
        else if (fall && clr_pend)           ack_seen <= 1'b0;
        else if (rise && ack_slot && !sda_in) ack_seen <= 1'b1;
    end
endmodule

// File: rtl/serbus_ack_busy.sv
// Top of the acknowledge/busy handshake controller: holds the control
// bits, builds the read word and joins the edge, count, line and status parts.
// Assumes reg_wr and xfer_start are single-cycle strobes.
module serbus_ack_busy
    import serbus_ab_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_en,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             cmd_pulse,
    input  logic             rel_pulse,
    input  logic             xfer_start,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sda_pull_low
);
    ctrl_t ctrl;
    logic  scl_fall, scl_rise, data_done, ack_slot;
    logic  ack_drive, busy, cmd_seen, ack_seen;
    logic  unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_W-1:F_ACKSEEN]};

    // Control bits load on any write, independent of the interface enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= '0;
        else if (reg_wr) ctrl <= '{auto_ack: reg_wdata[F_AUTO], busy_en: reg_wdata[F_BUSY]};
    end

    sbh_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .fall(scl_fall), .rise(scl_rise)
    );

    sbh_bit_counter #(.BITS(BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(if_en), .start(xfer_start), .fall(scl_fall),
        .data_done(data_done), .ack_slot(ack_slot)
    );

    sbh_line_ctrl u_line (
        .clk(clk), .rst_n(rst_n), .en(if_en), .start(xfer_start), .fall(scl_fall),
        .data_done(data_done), .trig_set(reg_wr & reg_wdata[F_TRIG]),
        .auto_ack(ctrl.auto_ack), .busy_en(ctrl.busy_en),
        .ack_drive(ack_drive), .busy(busy)
    );

    sbh_status u_stat (
        .clk(clk), .rst_n(rst_n), .en(if_en), .start(xfer_start), .fall(scl_fall),
        .rise(scl_rise), .ack_slot(ack_slot), .sda_in(sda_in),
        .cmd_pulse(cmd_pulse), .rel_pulse(rel_pulse),
        .cmd_seen(cmd_seen), .ack_seen(ack_seen)
    );

    // Read word: trigger bit and unused bits read as zero.
    always_comb begin
        reg_rdata            = '0;
        reg_rdata[F_AUTO]    = ctrl.auto_ack;
        reg_rdata[F_BUSY]    = ctrl.busy_en;
        reg_rdata[F_ACKSEEN] = ack_seen;
        reg_rdata[F_CMDSEEN] = cmd_seen;
    end

    assign sda_pull_low = ack_drive | busy;
endmodule

// File: rtl/serbus_ack_busy_chk.sv
// Checker for the handshake controller, bound to the top module.
module serbus_ack_busy_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       if_en,
    input logic       xfer_start,
    input logic       cmd_pulse,
    input logic       sda_in,
    input logic       scl_fall,
    input logic       scl_rise,
    input logic       ack_drive,
    input logic       busy,
    input logic [7:0] reg_rdata,
    input logic       sda_pull_low
);
    // R2/R3: an acknowledge only begins at a detected falling edge.
    p_ack_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drive) |-> $past(scl_fall));

    // R6: busy only begins right after an acknowledge.
    p_busy_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ack_drive));

    // R7: a transfer start releases the line.
    p_start_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && if_en) |=> !sda_pull_low);

    // R8: acknowledge detection needs a low sample at a rising edge.
    p_ackseen_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[3]) |-> $past(scl_rise && !sda_in));

    // R10: command flag rises only after a command pulse.
    p_cmd_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[4]) |-> $past(cmd_pulse));

    // R11: a disabled interface releases the line and drops both flags.
    p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |=> (!sda_pull_low && reg_rdata[4:3] == 2'b00));
endmodule

bind serbus_ack_busy serbus_ack_busy_chk u_chk (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .xfer_start(xfer_start),
    .cmd_pulse(cmd_pulse), .sda_in(sda_in), .scl_fall(scl_fall), .scl_rise(scl_rise),
    .ack_drive(ack_drive), .busy(busy), .reg_rdata(reg_rdata), .sda_pull_low(sda_pull_low)
);

// File: tb/serbus_ack_busy_tb.sv
module serbus_ack_busy_tb;
    logic clk = 0, rst_n = 0, if_en = 0, scl_in = 1, sda_in = 1;
    logic cmd_pulse = 0, rel_pulse = 0, xfer_start = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic sda_pull_low;
    int errors = 0, checks = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    serbus_ack_busy u_dut (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .scl_in(scl_in), .sda_in(sda_in),
        .cmd_pulse(cmd_pulse), .rel_pulse(rel_pulse), .xfer_start(xfer_start),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sda_pull_low(sda_pull_low)
    );

    // Behavioural reference: serial clock seen two system cycles late.
    bit sq[$] = '{0, 0, 0};
    bit m_acke, m_bsye, m_trig, m_ack, m_busy, m_cmd, m_ackd, m_pend;
    int m_cnt;
    always @(posedge clk) begin
        bit f, r;
        bit n_acke, n_bsye, n_trig, n_ack, n_busy, n_cmd, n_ackd, n_pend;
        int n_cnt;
        if (!rst_n) begin
            sq = '{0, 0, 0};
            {m_acke, m_bsye, m_trig, m_ack, m_busy, m_cmd, m_ackd, m_pend} = '0;
            m_cnt = 0;
        end else begin
            f = sq[0] && !sq[1];
            r = !sq[0] && sq[1];
            n_acke = reg_wr ? reg_wdata[1] : m_acke;
            n_bsye = reg_wr ? reg_wdata[2] : m_bsye;
            if (!if_en) begin
                {n_trig, n_ack, n_busy, n_cmd, n_ackd, n_pend} = '0;
                n_cnt = 0;
            end else begin
                n_cnt  = xfer_start ? 0 : (f && m_cnt < 9) ? m_cnt + 1 : m_cnt;
                n_ack  = xfer_start ? 0 : f ? (m_trig || (m_acke && m_cnt == 8)) : m_ack;
                n_busy = m_busy;
                if (xfer_start) n_busy = 0;
                else if (f) begin
                    if (m_ack && m_bsye) n_busy = 1;
                    else if (!m_bsye)    n_busy = 0;
                end
                n_trig = xfer_start ? 0 : (reg_wr && reg_wdata[0]) ? 1 : f ? 0 : m_trig;
                n_pend = xfer_start ? 1 : f ? 0 : m_pend;
                n_ackd = (f && m_pend) ? 0 : (r && m_cnt == 9 && !sda_in) ? 1 : m_ackd;
                n_cmd  = (xfer_start || rel_pulse) ? 0 : cmd_pulse ? 1 : m_cmd;
            end
            {m_acke, m_bsye, m_trig, m_ack, m_busy, m_cmd, m_ackd, m_pend} =
                {n_acke, n_bsye, n_trig, n_ack, n_busy, n_cmd, n_ackd, n_pend};
            m_cnt = n_cnt;
            void'(sq.pop_front());
            sq.push_back(scl_in);
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (rst_n) begin
            exp_rd = {3'b0, m_cmd, m_ackd, m_bsye, m_acke, 1'b0};
            checks++;
            if (reg_rdata !== exp_rd || sda_pull_low !== (m_ack || m_busy)) begin
                errors++;
                $display("FAIL %s model: rd=%h line=%b expected rd=%h line=%b",
                         phase, reg_rdata, sda_pull_low, exp_rd, m_ack || m_busy);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1; reg_wdata = d; @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic strobe_start();
        xfer_start = 1; @(negedge clk); xfer_start = 0;
    endtask

    task automatic sbit(input logic d);
        sda_in = d; scl_in = 0; repeat (4) @(negedge clk);
        scl_in = 1; repeat (4) @(negedge clk);
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) sbit(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        chk("R1 reset read", reg_rdata, 8'h00);
        chk("R1 reset line", {7'b0, sda_pull_low}, 8'h00);
        if_en = 1; @(negedge clk);

        phase = "R2";
        wr(8'h01);
        chk("R2 trigger reads 0", reg_rdata, 8'h00);
        sbit(1); chk("R2 ack on next fall", {7'b0, sda_pull_low}, 8'h01);
        sbit(1); chk("R5 ack one bit, trigger self-cleared", {7'b0, sda_pull_low}, 8'h00);

        phase = "R4";
        strobe_start(); wr(8'h00);
        bits(9); chk("R4 no ack without enables", {7'b0, sda_pull_low}, 8'h00);

        phase = "R3";
        strobe_start(); wr(8'h02);
        for (int i = 0; i < 8; i++) begin
            sbit(1); chk("R3 no early ack", {7'b0, sda_pull_low}, 8'h00);
        end
        sbit(0); chk("R3 auto ack on 9th fall", {7'b0, sda_pull_low}, 8'h01);
        chk("R8 ack seen on low sample", {7'b0, reg_rdata[3]}, 8'h01);
        sbit(1); chk("R5 ack ends next fall", {7'b0, sda_pull_low}, 8'h00);

        phase = "R9";
        strobe_start();
        chk("R9 flag held until fall", {7'b0, reg_rdata[3]}, 8'h01);
        sbit(1); chk("R9 flag cleared at fall", {7'b0, reg_rdata[3]}, 8'h00);

        phase = "R3late";
        strobe_start(); wr(8'h00);
        bits(8); wr(8'h02);
        sbit(1); chk("R3 late enable acks", {7'b0, sda_pull_low}, 8'h01);
        chk("R8 high sample leaves flag clear", {7'b0, reg_rdata[3]}, 8'h00);

        phase = "R6";
        strobe_start(); wr(8'h06);
        bits(9); chk("R6 ack before busy", {7'b0, sda_pull_low}, 8'h01);
        sbit(1); chk("R6 busy after ack", {7'b0, sda_pull_low}, 8'h01);
        sbit(1); chk("R6 busy held", {7'b0, sda_pull_low}, 8'h01);
        wr(8'h02);
        chk("R6 busy held until fall", {7'b0, sda_pull_low}, 8'h01);
        sbit(1); chk("R6 busy ends at fall", {7'b0, sda_pull_low}, 8'h00);

        phase = "R7";
        strobe_start(); wr(8'h06);
        bits(10); chk("R7 busy before start", {7'b0, sda_pull_low}, 8'h01);
        scl_in = 1; repeat (2) @(negedge clk);
        strobe_start();
        chk("R7 start releases line", {7'b0, sda_pull_low}, 8'h00);
        chk("R7 busy enable kept", {7'b0, reg_rdata[2]}, 8'h01);

        phase = "R10";
        cmd_pulse = 1; @(negedge clk); cmd_pulse = 0;
        chk("R10 cmd sets", {7'b0, reg_rdata[4]}, 8'h01);
        rel_pulse = 1; @(negedge clk); rel_pulse = 0;
        chk("R10 release clears", {7'b0, reg_rdata[4]}, 8'h00);
        cmd_pulse = 1; @(negedge clk); cmd_pulse = 0;
        cmd_pulse = 1; xfer_start = 1; @(negedge clk); cmd_pulse = 0; xfer_start = 0;
        chk("R10 start clear wins", {7'b0, reg_rdata[4]}, 8'h00);

        phase = "R11";
        cmd_pulse = 1; @(negedge clk); cmd_pulse = 0;
        wr(8'h07);
        if_en = 0; @(negedge clk);
        chk("R11 disabled read", reg_rdata, 8'h06);
        sbit(1); chk("R11 trigger dropped", {7'b0, sda_pull_low}, 8'h00);
        wr(8'h02);
        chk("R11 writable while off", reg_rdata, 8'h02);
        if_en = 1; @(negedge clk);

        phase = "R12";
        wr(8'hFF);
        chk("R12 write mask", reg_rdata, 8'h06);
        wr(8'h18);
        chk("R12 status bits not writable", reg_rdata, 8'h00);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule